// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a management master for external Ethernet PHYs. Software reaches it through a small word-addressed register bus. To write a PHY register, software loads the 16-bit data word, then writes a command word that carries an opcode, a PHY address and a register address. To read, software writes only the command word. An accepted command raises a busy flag and starts one serial frame on the two-wire management interface. Software polls the busy flag, and once it drops a read result sits in the data word.

The management clock comes from the system clock through an even divide ratio set by a parameter. The serial data pin is a split output, output-enable and input triple, so the pad tristate buffer lives outside the block. The output changes only on falling management clock edges. Input bits are taken on rising edges.

Register word addresses: 0 is the command word, 1 is the data word, 2 is the status word, and 3 reads as zero.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command, data and status words read as zero, the management data output enable is low and the data output idles high.
- R2: The command word holds the opcode in bits 15:14, the PHY address in bits 9:5 and the register address in bits 4:0. Every other bit reads back as zero.
- R3: A command write with opcode 01 (write) or 10 (read), made while the block is idle, sets status bit 0 (busy) in the next cycle.
- R4: Each frame carries 64 bits, MSB first: 32 ones, then 01, the 2-bit opcode, the 5-bit PHY address, the 5-bit register address, 2 turnaround bits and 16 data bits.
- R5: In a write frame the block drives turnaround 10 and then the data word as it stood when the command was accepted. The output enable stays high for all 64 bits.
- R6: In a read frame the output enable drops from the first turnaround bit through the last data bit. The 16 input bits are taken on MDC rising edges, MSB first, and they are in the data word once busy clears.
- R7: Busy stays set until the falling MDC edge that follows the rising edge of the last frame bit. While busy is clear the output enable is low.
- R8: MDC has a period of DIV_RATIO system clocks with equal high and low halves. The data output changes only at falling MDC edges.
- R9: Writes to the command word or the data word while busy is set are ignored. Neither the stored word nor the frame in progress changes.
- R10: A command write with opcode 00 or 11 starts no frame and leaves busy clear. The command word still stores the fields.
- R11: Status bits 31:1 read as zero, and bit 0 reads as the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write enable for the access |
| reg_addr_i | input | 2 | Word address (0 command, 1 data, 2 status) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe_o | output | 1 | Management data output enable (low means released) |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
The hardest situation to reach from the ports is a register write that lands in the middle of a running frame. The bench has to find the right cycle by following the MDC edges it observes. A bench model of the PHY counts falling MDC edges from the start of the frame. At bit 20 it writes a new command, and at bit 21 it writes a new data word. It then checks that the rest of the frame, the stored command and the data word are unchanged. The same model drives read response bits right after each falling edge, so that the block's sampling on rising edges is exercised against random data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_BITS  = 32;
  localparam int FRAME_W   = PRE_BITS + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int POS_W     = $clog2(FRAME_W);
  localparam int TA_POS    = FRAME_W - DATA_W - 2;
  localparam int DATA_POS  = FRAME_W - DATA_W;
  localparam int CMD_FLD_W = 2 + PHY_W + REG_W;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_BAD  = 2'b11
  } mdio_op_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = DIV_RATIO / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = (cnt_q == CW'(HALF - 1));
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  mdio_op_e          op_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [POS_W-1:0]   pos_q;
  logic               armed_q, active_q, is_rd_q;
  logic [DATA_W-1:0]  rd_sr_q;
  logic [FRAME_W-1:0] frame;
  logic [POS_W-1:0]   pos_nxt;
  logic               is_rd_in;

  assign is_rd_in = (op_i == OP_RD);
  // read frames leave TA and data released (ones are placeholders)
  assign frame = {{PRE_BITS{1'b1}}, 2'b01, op_i, phy_i, reg_i,
                  is_rd_in ? 2'b11 : 2'b10,
                  is_rd_in ? {DATA_W{1'b1}} : wdata_i};
  assign pos_nxt = pos_q + 1'b1;
  assign rdata_o = rd_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      pos_q     <= '0;
      armed_q   <= 1'b0;
      active_q  <= 1'b0;
      is_rd_q   <= 1'b0;
      rd_sr_q   <= '0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        sr_q    <= frame;
        is_rd_q <= is_rd_in;
        armed_q <= 1'b1;
      end else if (fall_i && armed_q) begin
        armed_q   <= 1'b0;
        active_q  <= 1'b1;
        pos_q     <= '0;
        mdio_o    <= sr_q[FRAME_W-1];
        mdio_oe_o <= 1'b1;
        sr_q      <= sr_q << 1;
      end else if (fall_i && active_q) begin
        if (pos_q == POS_W'(FRAME_W - 1)) begin
          active_q  <= 1'b0;
          mdio_oe_o <= 1'b0;
          mdio_o    <= 1'b1;
          done_o    <= 1'b1;
        end else begin
          pos_q     <= pos_nxt;
          mdio_o    <= sr_q[FRAME_W-1];
          mdio_oe_o <= !(is_rd_q && (pos_nxt >= POS_W'(TA_POS)));
          sr_q      <= sr_q << 1;
        end
      end
      if (rise_i && active_q && is_rd_q && (pos_q >= POS_W'(DATA_POS)))
        rd_sr_q <= {rd_sr_q[DATA_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              start_o,
  output mdio_op_e          op_o,
  output logic [PHY_W-1:0]  phy_o,
  output logic [REG_W-1:0]  reg_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o
);
  mdio_op_e          op_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] data_q;
  logic              busy_q, start_q;
  logic              wr_cmd, wr_dat, op_ok;
  mdio_op_e          op_in;
  logic              unused_wbits;

  assign op_in  = mdio_op_e'(wdata_i[15:14]);
  assign wr_cmd = sel_i & we_i & (addr_i == ADDR_CMD) & ~busy_q;
  assign wr_dat = sel_i & we_i & (addr_i == ADDR_DATA) & ~busy_q;
  assign op_ok  = (op_in == OP_WR) || (op_in == OP_RD);
  assign unused_wbits = ^{wdata_i[31:16], wdata_i[13:10]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_NONE;
      phy_q   <= '0;
      reg_q   <= '0;
      data_q  <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr_cmd) begin
        op_q  <= op_in;
        phy_q <= wdata_i[PHY_W+REG_W-1:REG_W];
        reg_q <= wdata_i[REG_W-1:0];
        if (op_ok) begin
          busy_q  <= 1'b1;
          start_q <= 1'b1;
        end
      end
      if (wr_dat) data_q <= wdata_i[DATA_W-1:0];
      if (done_i) begin
        busy_q <= 1'b0;
        if (op_q == OP_RD) data_q <= rd_data_i;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CMD:  rdata_o = {16'b0, op_q, 4'b0, phy_q, reg_q};
      ADDR_DATA: rdata_o = {{(32-DATA_W){1'b0}}, data_q};
      ADDR_STAT: rdata_o = {31'b0, busy_q};
      default:   rdata_o = '0;
    endcase
  end

  assign start_o = start_q;
  assign op_o    = op_q;
  assign phy_o   = phy_q;
  assign reg_o   = reg_q;
  assign data_o  = data_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_RATIO = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_sel_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic                 rise, fall, start, done, busy;
  mdio_op_e             cmd_op;
  logic [PHY_W-1:0]     cmd_phy;
  logic [REG_W-1:0]     cmd_reg;
  logic [DATA_W-1:0]    data_word, rd_data;
  logic [CMD_FLD_W-1:0] cmd_fields;

  assign cmd_fields = {cmd_op, cmd_phy, cmd_reg};

  mdio_clkgen #(.DIV_RATIO(DIV_RATIO)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
  );

  mdio_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sel_i(reg_sel_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .done_i(done), .rd_data_i(rd_data), .start_o(start),
    .op_o(cmd_op), .phy_o(cmd_phy), .reg_o(cmd_reg),
    .data_o(data_word), .busy_o(busy)
  );

  mdio_frame_engine u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall),
    .start_i(start), .op_i(cmd_op), .phy_i(cmd_phy), .reg_i(cmd_reg),
    .wdata_i(data_word), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .done_o(done), .rdata_o(rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_sel_i,
  input logic                 reg_we_i,
  input logic [1:0]           reg_addr_i,
  input logic [31:0]          reg_wdata_i,
  input logic                 mdc_o,
  input logic                 mdio_o,
  input logic                 mdio_oe_o,
  input logic                 busy_i,
  input logic [CMD_FLD_W-1:0] cmd_fields_i
);
  logic       cmd_wr;
  logic [1:0] op_w;

  assign cmd_wr = reg_sel_i & reg_we_i & (reg_addr_i == ADDR_CMD);
  assign op_w   = reg_wdata_i[15:14];

  // R3
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && (op_w == 2'b01 || op_w == 2'b10)) |=> busy_i);

  // R10
  bad_op_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && (op_w == 2'b00 || op_w == 2'b11)) |=> !busy_i);

  // R9
  busy_cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy_i) |=> $stable(cmd_fields_i));

  // R7
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdio_oe_o);

  // R8
  fall_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> $fell(mdc_o));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .mdc_o(mdc_o),
  .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .busy_i(busy), .cmd_fields_i(cmd_fields)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, mdoe;
  logic        mdi = 1'b1;

  int total = 0, bad = 0;
  int fall_viol = 0;
  bit finished = 0;
  time last_fall = 0;

  always #4 clk = ~clk;

  mdio_mgmt_ctrl #(.DIV_RATIO(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdoe), .mdio_i(mdi)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [63:0] exp_frame(logic [1:0] op, logic [4:0] phy, logic [4:0] ra, logic [15:0] wd);
    bit rd = (op == 2'b10);
    return {32'hFFFF_FFFF, 2'b01, op, phy, ra, rd ? 2'b00 : 2'b10, rd ? 16'h0 : wd};
  endfunction

  function automatic logic [63:0] exp_oe(logic [1:0] op);
    return (op == 2'b10) ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  // R8: MDIO may move only at a falling MDC edge
  always @(negedge mdc) last_fall = $time;
  always @(mdo) if (rst_n) begin
    #1;
    if (!(mdc == 1'b0 && last_fall == $time - 1)) fall_viol++;
  end

  task automatic run_txn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] resp, input bit intrude);
    logic [63:0] cap_o, cap_oe, ef, em;
    logic [31:0] r;
    bit rd = (op == 2'b10);
    cap_o = '0; cap_oe = '0;
    if (!rd) bus_wr(2'd1, {16'h0, wd});
    bus_wr(2'd0, {16'h0, op, 4'h0, phy, ra});
    bus_rd(2'd2, r);
    check(r == 32'd1, "R3/R11 busy after command", 64'(r), 64'd1);
    @(negedge mdc);
    for (int k = 0; k < 64; k++) begin
      #1 mdi = (k >= 48) ? resp[63-k] : 1'b1;
      if (intrude && k == 20) bus_wr(2'd0, {16'h0, ~op, 4'h0, ~phy, ~ra});
      if (intrude && k == 21) bus_wr(2'd1, {16'h0, ~wd});
      @(posedge mdc);
      cap_o[63-k] = mdo; cap_oe[63-k] = mdoe;
      if (k < 63) @(negedge mdc);
    end
    bus_rd(2'd2, r);
    check(r[0] == 1'b1, "R7 busy held through last bit", 64'(r), 64'd1);
    @(negedge mdc);
    repeat (2) @(posedge clk);
    bus_rd(2'd2, r);
    check(r == 32'd0, "R7 busy clear after frame", 64'(r), 64'd0);
    check(mdoe == 1'b0, "R7 released when idle", 64'(mdoe), 64'd0);
    ef = exp_frame(op, phy, ra, wd); em = exp_oe(op);
    check(cap_oe == em, rd ? "R6 output enable" : "R5 output enable", cap_oe, em);
    check((cap_o & em & 64'hFFFF_FFFF_FFFF_0000) == (ef & em & 64'hFFFF_FFFF_FFFF_0000),
          "R4 frame header", cap_o & em, ef & em);
    if (!rd) check(cap_o[17:0] == ef[17:0], "R5 turnaround and data", 64'(cap_o[17:0]), 64'(ef[17:0]));
    bus_rd(2'd1, r);
    if (rd) check(r == {16'h0, resp}, "R6 read data", 64'(r), 64'(resp));
    else    check(r == {16'h0, wd}, "R9 data word kept", 64'(r), 64'(wd));
    bus_rd(2'd0, r);
    check(r == {16'h0, op, 4'h0, phy, ra}, "R2/R9 command readback", 64'(r),
          64'({16'h0, op, 4'h0, phy, ra}));
  endtask

  initial begin
    logic [31:0] r;
    time t0, t1, t2;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1
    bus_rd(2'd0, r); check(r == 0, "R1 command reset", 64'(r), 0);
    bus_rd(2'd1, r); check(r == 0, "R1 data reset", 64'(r), 0);
    bus_rd(2'd2, r); check(r == 0, "R1 status reset", 64'(r), 0);
    check(mdoe == 0 && mdo == 1, "R1 pin idle", {mdoe, mdo}, 64'b01);
    // R8 period and duty
    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    check(t2 - t0 == DIV * 8, "R8 MDC period", 64'(t2 - t0), 64'(DIV * 8));
    check(t1 - t0 == DIV * 4, "R8 MDC high half", 64'(t1 - t0), 64'(DIV * 4));
    // R10 and R2 reserved bits
    bus_wr(2'd0, 32'hFFFF_FFFF);
    bus_rd(2'd2, r); check(r == 0, "R10 opcode 11 no busy", 64'(r), 0);
    bus_rd(2'd0, r); check(r == 32'h0000_C3FF, "R2 reserved zero", 64'(r), 64'h0000_C3FF);
    bus_wr(2'd0, 32'h0000_0123);
    repeat (2 * DIV * 2) begin
      @(negedge clk);
      if (mdoe) break;
    end
    check(mdoe == 0, "R10 opcode 00 no frame", 64'(mdoe), 0);
    bus_rd(2'd2, r); check(r == 0, "R10 opcode 00 no busy", 64'(r), 0);
    // directed corners
    run_txn(2'b01, 5'h1F, 5'h00, 16'hA5C3, 16'h0, 1'b0);
    run_txn(2'b10, 5'h00, 5'h1F, 16'h0, 16'h8001, 1'b0);
    run_txn(2'b01, 5'h0A, 5'h15, 16'h3C0F, 16'h0, 1'b1);  // R9 mid-frame writes
    run_txn(2'b10, 5'h11, 5'h02, 16'h0, 16'h7FFE, 1'b1);  // R9 mid-frame writes
    // random
    for (int i = 0; i < 10; i++) begin
      logic [1:0] op = ($urandom % 2) ? 2'b10 : 2'b01;
      run_txn(op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 1'b0);
    end
    check(fall_viol == 0, "R8 MDIO moves on falling MDC", 64'(fall_viol), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule